// File: doc/BRIEF.md
# Clock-Enable Prescaler Tree

This block runs entirely on one fast system clock and, instead of making divided clocks, produces single-cycle enable strobes for every clocked domain below it. A main bus strobe is divided down from the system clock. Two peripheral bus strobes, one fast and one slow, are cascaded below the main bus strobe, each with its own divisor. Logic in a slower domain stays on the system clock and advances only in cycles where its strobe is high.

Four more taps hang off the bus strobes. Each peripheral bus has a timer strobe that runs at the bus rate when that bus divisor is 1, and at twice the bus rate otherwise. An ADC strobe divides the fast peripheral bus strobe by 2, 4, 6 or 8. A system tick strobe is either the main bus strobe divided by 8 or the main bus strobe itself.

Every derived strobe coincides with a pulse of its parent, so all domains stay phase-aligned. A new divisor code is taken only when the current period of that stage ends. A registered flag reports a configuration in which the slow peripheral bus would run faster than half the system clock.

Top module: `ce_prescale_tree`

## Requirements
- R1: `main_code` picks the main divisor H as follows: code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16, 5 gives 64, 6 gives 128, 7 gives 256, and any code from 8 to 15 gives 512. `en_main` pulses once every H cycles.
- R2: `fast_code` and `slow_code` each pick a bus divisor as follows: code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and any code from 4 to 7 gives 16. `en_pfast` pulses every H*F system cycles and `en_pslow` every H*S system cycles.
- R3: When a bus divisor is 1, that bus's timer strobe pulses every H cycles. When the bus divisor B is greater than 1, the timer strobe pulses evenly every H*B/2 cycles.
- R4: `adc_sel` values 0, 1, 2 and 3 divide `en_pfast` by 2, 4, 6 and 8, so `en_adc` pulses every H*F*(2*adc_sel+2) cycles.
- R5: With `tick_sel` at 0, `en_tick` pulses every 8*H cycles. With `tick_sel` at 1, `en_tick` equals `en_main`.
- R6: A strobe is high only in a cycle where its parent strobe is high. `en_pfast`, `en_pslow`, both timer strobes and `en_tick` have `en_main` as parent. `en_adc` has `en_pfast` as parent.
- R7: A change to a divisor code leaves the period already running untouched. The new divisor applies from the first period that begins after it.
- R8: A synchronous active-high `rst` clears all counters and sets every divisor to 1, except the ADC divisor, which is set to 2. In the first cycle after reset every strobe is high and `config_error` is low, and the first ADC interval lasts 2 fast-bus pulses whatever `adc_sel` holds.
- R9: `config_error` is registered. One cycle after `main_code` and `slow_code` are both 0 it is high. In every other case it is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_code | input | 4 | Main bus divisor code |
| fast_code | input | 3 | Fast peripheral bus divisor code |
| slow_code | input | 3 | Slow peripheral bus divisor code |
| adc_sel | input | 2 | ADC divisor select (2, 4, 6, 8) |
| tick_sel | input | 1 | 1: tick equals main strobe; 0: main strobe divided by 8 |
| en_main | output | 1 | Main bus enable strobe |
| en_pfast | output | 1 | Fast peripheral bus enable strobe |
| en_pslow | output | 1 | Slow peripheral bus enable strobe |
| en_tmr_fast | output | 1 | Timer strobe for the fast peripheral bus |
| en_tmr_slow | output | 1 | Timer strobe for the slow peripheral bus |
| en_adc | output | 1 | ADC enable strobe |
| en_tick | output | 1 | System tick enable strobe |
| config_error | output | 1 | Slow bus would exceed half the system rate |

## Verification
The bench measures the interval between consecutive pulses of every strobe across configurations. These include divisor 1 on one bus and not the other, which exercises the timer doubling rule in both of its cases, and out-of-range codes, which must saturate at the largest divisor. A design that doubled the timer strobe at divisor 1, or that wrapped a saturated code to a small divisor, shows a wrong interval. The bench changes a divisor partway through a period. A design that reloads immediately shows a shortened interval instead of one full old period followed by the new one. It also holds `adc_sel` at 3 through reset, to catch a design that starts the ADC tap at the selected divisor rather than at 2. A monitor counts any cycle in which a child strobe fires without its parent.

// File: rtl/ce_tree_pkg.sv
package ce_tree_pkg;
  localparam int MAIN_CODE_W  = 4;
  localparam int BUS_CODE_W   = 3;
  localparam int ADC_SEL_W    = 2;
  localparam int MAIN_MAX_DIV = 512;
  localparam int BUS_MAX_DIV  = 16;
  localparam int ADC_MAX_DIV  = 2 * (2 ** ADC_SEL_W);
  localparam int MAIN_DIV_W   = $clog2(MAIN_MAX_DIV) + 1;
  localparam int BUS_DIV_W    = $clog2(BUS_MAX_DIV) + 1;
  localparam int ADC_DIV_W    = $clog2(ADC_MAX_DIV) + 1;
  localparam int BUS_TOP_CODE = $clog2(BUS_MAX_DIV);
  localparam int MAIN_GAP_CODE = 4;  // codes above this skip divide-by-32
  localparam int MAIN_TOP_CODE = $clog2(MAIN_MAX_DIV) - 1;

  function automatic logic [MAIN_DIV_W-1:0] main_div_of(input logic [MAIN_CODE_W-1:0] code);
    logic [MAIN_DIV_W-1:0] one;
    one = MAIN_DIV_W'(1);
    if (code <= MAIN_CODE_W'(MAIN_GAP_CODE))
      return one << code;
    else if (code <= MAIN_CODE_W'(MAIN_TOP_CODE))
      return one << (code + MAIN_CODE_W'(1));
    else
      return MAIN_DIV_W'(MAIN_MAX_DIV);
  endfunction

  function automatic logic [BUS_DIV_W-1:0] bus_div_of(input logic [BUS_CODE_W-1:0] code);
    logic [BUS_DIV_W-1:0] one;
    one = BUS_DIV_W'(1);
    if (code <= BUS_CODE_W'(BUS_TOP_CODE))
      return one << code;
    else
      return BUS_DIV_W'(BUS_MAX_DIV);
  endfunction

  function automatic logic [ADC_DIV_W-1:0] adc_div_of(input logic [ADC_SEL_W-1:0] sel);
    return ADC_DIV_W'((int'(sel) + 1) * 2);
  endfunction
endpackage

// File: rtl/ce_div_stage.sv
// Generic enable divider: counts parent pulses and fires on count zero.
// A requested divisor is taken only at the wrap point of the running period.
module ce_div_stage #(
  parameter int DIV_W     = 4,
  parameter int RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             parent_en,
  input  logic [DIV_W-1:0] div_req,
  output logic             out_en
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             wrap;

  assign wrap = (cnt_q == div_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= DIV_W'(RESET_DIV);
    end else if (parent_en) begin
      if (wrap) begin
        cnt_q <= '0;
        div_q <= (div_req == '0) ? DIV_W'(1) : div_req;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign out_en = parent_en && (cnt_q == '0);
endmodule

// File: rtl/ce_bus_stage.sv
// Peripheral bus divider with a timer tap that doubles the bus rate
// whenever the latched bus divisor exceeds one.
module ce_bus_stage #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             parent_en,
  input  logic [DIV_W-1:0] div_req,
  output logic             bus_en,
  output logic             tmr_en
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             wrap;
  logic             unity;
  logic             at_half;

  assign wrap    = (cnt_q == div_q - DIV_W'(1));
  assign unity   = (div_q == DIV_W'(1));
  assign at_half = (cnt_q == (div_q >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= DIV_W'(1);
    end else if (parent_en) begin
      if (wrap) begin
        cnt_q <= '0;
        div_q <= (div_req == '0) ? DIV_W'(1) : div_req;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign bus_en = parent_en && (cnt_q == '0);
  assign tmr_en = parent_en && ((cnt_q == '0) || (!unity && at_half));
endmodule

// File: rtl/ce_cfg_check.sv
// Registered rate-limit flag: slow bus at full system rate is illegal.
module ce_cfg_check
  import ce_tree_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MAIN_CODE_W-1:0] main_code,
  input  logic [BUS_CODE_W-1:0]  slow_code,
  output logic                   err
);
  logic too_fast;

  // Slow rate = sys / (H*S); above sys/2 only when H*S == 1.
  assign too_fast = (main_div_of(main_code) == MAIN_DIV_W'(1)) &&
                    (bus_div_of(slow_code) == BUS_DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= too_fast;
  end
endmodule

// File: rtl/ce_prescale_tree.sv
module ce_prescale_tree
  import ce_tree_pkg::*;
#(
  parameter int TICK_DIV = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MAIN_CODE_W-1:0] main_code,
  input  logic [BUS_CODE_W-1:0]  fast_code,
  input  logic [BUS_CODE_W-1:0]  slow_code,
  input  logic [ADC_SEL_W-1:0]   adc_sel,
  input  logic                   tick_sel,
  output logic                   en_main,
  output logic                   en_pfast,
  output logic                   en_pslow,
  output logic                   en_tmr_fast,
  output logic                   en_tmr_slow,
  output logic                   en_adc,
  output logic                   en_tick,
  output logic                   config_error
);
  localparam int NUM_BUS    = 2;
  localparam int BUS_FAST   = 0;
  localparam int BUS_SLOW   = 1;
  localparam int TICK_DIV_W = $clog2(TICK_DIV) + 1;

  logic [BUS_CODE_W-1:0] bus_code [NUM_BUS];
  logic [NUM_BUS-1:0]    bus_en;
  logic [NUM_BUS-1:0]    tmr_en;
  logic                  tick_div_en;

  assign bus_code[BUS_FAST] = fast_code;
  assign bus_code[BUS_SLOW] = slow_code;

  ce_div_stage #(.DIV_W(MAIN_DIV_W), .RESET_DIV(1)) u_main (
    .clk       (clk),
    .rst       (rst),
    .parent_en (1'b1),
    .div_req   (main_div_of(main_code)),
    .out_en    (en_main)
  );

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    ce_bus_stage #(.DIV_W(BUS_DIV_W)) u_bus (
      .clk       (clk),
      .rst       (rst),
      .parent_en (en_main),
      .div_req   (bus_div_of(bus_code[b])),
      .bus_en    (bus_en[b]),
      .tmr_en    (tmr_en[b])
    );
  end

  assign en_pfast    = bus_en[BUS_FAST];
  assign en_pslow    = bus_en[BUS_SLOW];
  assign en_tmr_fast = tmr_en[BUS_FAST];
  assign en_tmr_slow = tmr_en[BUS_SLOW];

  ce_div_stage #(.DIV_W(ADC_DIV_W), .RESET_DIV(2)) u_adc (
    .clk       (clk),
    .rst       (rst),
    .parent_en (en_pfast),
    .div_req   (adc_div_of(adc_sel)),
    .out_en    (en_adc)
  );

  ce_div_stage #(.DIV_W(TICK_DIV_W), .RESET_DIV(TICK_DIV)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .parent_en (en_main),
    .div_req   (TICK_DIV_W'(TICK_DIV)),
    .out_en    (tick_div_en)
  );

  assign en_tick = tick_sel ? en_main : tick_div_en;

  ce_cfg_check u_cfg (
    .clk       (clk),
    .rst       (rst),
    .main_code (main_code),
    .slow_code (slow_code),
    .err       (config_error)
  );
endmodule

// File: rtl/ce_prescale_tree_chk.sv
module ce_prescale_tree_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] main_code,
  input logic [2:0] slow_code,
  input logic       en_main,
  input logic       en_pfast,
  input logic       en_pslow,
  input logic       en_tmr_fast,
  input logic       en_tmr_slow,
  input logic       en_adc,
  input logic       en_tick,
  input logic       config_error
);
  AST_PFAST_PHASE: assert property (@(posedge clk) disable iff (rst) en_pfast |-> en_main);      // R6
  AST_PSLOW_PHASE: assert property (@(posedge clk) disable iff (rst) en_pslow |-> en_main);      // R6
  AST_TMRF_PHASE:  assert property (@(posedge clk) disable iff (rst) en_tmr_fast |-> en_main);   // R3
  AST_TMRS_PHASE:  assert property (@(posedge clk) disable iff (rst) en_tmr_slow |-> en_main);   // R3
  AST_ADC_PHASE:   assert property (@(posedge clk) disable iff (rst) en_adc |-> en_pfast);       // R4
  AST_TICK_PHASE:  assert property (@(posedge clk) disable iff (rst) en_tick |-> en_main);       // R5
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_main && en_pfast && en_pslow && en_adc && !config_error));               // R8
  AST_CFG_FLAG:    assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (config_error == $past((main_code == 4'd0) && (slow_code == 3'd0))));       // R9
endmodule

bind ce_prescale_tree ce_prescale_tree_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .main_code    (main_code),
  .slow_code    (slow_code),
  .en_main      (en_main),
  .en_pfast     (en_pfast),
  .en_pslow     (en_pslow),
  .en_tmr_fast  (en_tmr_fast),
  .en_tmr_slow  (en_tmr_slow),
  .en_adc       (en_adc),
  .en_tick      (en_tick),
  .config_error (config_error)
);

// File: tb/ce_prescale_tree_test.sv
module ce_prescale_tree_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] main_code = '0;
  logic [2:0] fast_code = '0;
  logic [2:0] slow_code = '0;
  logic [1:0] adc_sel = '0;
  logic       tick_sel = 1'b0;
  logic en_main, en_pfast, en_pslow, en_tmr_fast, en_tmr_slow, en_adc, en_tick, config_error;

  int checks = 0;
  int failures = 0;
  int phase_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  ce_prescale_tree uut (
    .clk(clk), .rst(rst), .main_code(main_code), .fast_code(fast_code),
    .slow_code(slow_code), .adc_sel(adc_sel), .tick_sel(tick_sel),
    .en_main(en_main), .en_pfast(en_pfast), .en_pslow(en_pslow),
    .en_tmr_fast(en_tmr_fast), .en_tmr_slow(en_tmr_slow), .en_adc(en_adc),
    .en_tick(en_tick), .config_error(config_error)
  );

  logic [6:0] strb;
  assign strb = {en_tick, en_adc, en_tmr_slow, en_tmr_fast, en_pslow, en_pfast, en_main};

  // Vector: [12:9] main code, [8:6] fast code, [5:3] slow code, [2:1] adc_sel, [0] tick_sel
  localparam int NVEC = 6;
  localparam logic [12:0] VEC [NVEC] = '{
    {4'd0, 3'd0, 3'd1, 2'd0, 1'b0},
    {4'd1, 3'd2, 3'd3, 2'd1, 1'b1},
    {4'd4, 3'd1, 3'd0, 2'd3, 1'b0},
    {4'd0, 3'd0, 3'd0, 2'd2, 1'b0},
    {4'd5, 3'd4, 3'd2, 2'd0, 1'b1},
    {4'd9, 3'd0, 3'd6, 2'd0, 1'b0}
  };

  function automatic int h_of(input logic [3:0] c);
    case (c)
      4'd0: return 1;   4'd1: return 2;   4'd2: return 4;   4'd3: return 8;
      4'd4: return 16;  4'd5: return 64;  4'd6: return 128; 4'd7: return 256;
      default: return 512;
    endcase
  endfunction

  function automatic int b_of(input logic [2:0] c);
    return (c > 3'd4) ? 16 : (1 << c);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_pulse(input int idx);
    int n = 0;
    while (!strb[idx] && n < 70000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic gap(input int idx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!strb[idx] && n < 70000);
  endtask

  // R6 monitor: no child strobe without its parent
  always @(negedge clk) begin
    if (!rst) begin
      if ((en_pfast && !en_main) || (en_pslow && !en_main) || (en_tmr_fast && !en_main) ||
          (en_tmr_slow && !en_main) || (en_adc && !en_pfast) || (en_tick && !en_main))
        phase_bad++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int g;
    string tags [7];
    int expv [7];
    tags = '{"R1", "R2", "R2", "R3", "R3", "R4", "R5"};

    // R8: reset state with adc_sel held at 3
    adc_sel = 2'd3;
    do_reset();
    check("R8", "strobes after reset", int'(strb), 7'h7F);
    check("R8", "config_error after reset", int'(config_error), 0);
    gap(5, g);
    check("R8", "first adc interval", g, 2);
    check("R9", "config_error codes zero", int'(config_error), 1);
    gap(5, g);
    check("R4", "adc interval sel3 div1", g, 8);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      int hh, ff, ss, aa;
      main_code = VEC[v][12:9];
      fast_code = VEC[v][8:6];
      slow_code = VEC[v][5:3];
      adc_sel   = VEC[v][2:1];
      tick_sel  = VEC[v][0];
      hh = h_of(main_code); ff = b_of(fast_code); ss = b_of(slow_code);
      aa = 2 * (int'(adc_sel) + 1);
      expv[0] = hh;
      expv[1] = hh * ff;
      expv[2] = hh * ss;
      expv[3] = (ff == 1) ? hh : hh * ff / 2;
      expv[4] = (ss == 1) ? hh : hh * ss / 2;
      expv[5] = hh * ff * aa;
      expv[6] = tick_sel ? hh : 8 * hh;
      do_reset();
      repeat (4 * hh * ff + 16) @(negedge clk);
      check("R9", $sformatf("config_error vec%0d", v), int'(config_error),
            (hh == 1 && ss == 1) ? 1 : 0);
      for (int k = 0; k < 7; k++) begin
        wait_pulse(k);
        gap(k, g);
        check(tags[k], $sformatf("interval vec%0d strobe%0d", v, k), g, expv[k]);
      end
    end

    // R7: main divisor change mid-period
    main_code = 4'd3; fast_code = '0; slow_code = 3'd1; adc_sel = '0; tick_sel = 1'b0;
    do_reset();
    repeat (40) @(negedge clk);
    wait_pulse(0);
    main_code = 4'd1;
    gap(0, g);
    check("R7", "old period completes", g, 8);
    gap(0, g);
    check("R7", "new period applies", g, 2);

    // R9: flag follows the configuration one cycle later
    main_code = 4'd0; slow_code = 3'd1;
    @(negedge clk);
    slow_code = 3'd0;
    @(negedge clk);
    check("R9", "flag rises", int'(config_error), 1);
    slow_code = 3'd1;
    @(negedge clk);
    check("R9", "flag falls", int'(config_error), 0);

    check("R6", "child strobe without parent", phase_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule